// File: doc/BRIEF.md
# Pipeline Read-After-Write Stall Interlock

This block is the hazard check for a five-stage in-order pipeline (Fetch, Decode, Compute, Memory, Writeback) that has no operand bypass paths. Every cycle it takes the source register tags of the instruction sitting in Decode. It compares them with the destination tags held in the three younger interstage buffers that feed Compute, Memory and Writeback. When a live source matches a pending write, the block raises three control lines together. The first holds the program counter. The second freezes the Fetch/Decode buffer, so the dependent instruction stays in Decode. The third loads a no-operation control word into the Decode/Compute buffer.

The producer and every instruction ahead of it keep moving. Each stalled cycle therefore sends one bubble down the pipe, and the stall ends on its own once the producer has left Writeback. The register file is written at the end of Writeback and read in Decode in a later cycle. A consumer that directly follows its producer therefore waits three cycles. The outputs are purely combinational from the tags. The clock and reset serve only the built-in checks.

Top module: `hazard_interlock`

## Requirements
- R1: A consumer directly behind its producer (no instruction between them) is held in Decode for exactly 3 cycles.
- R2: With one, two or three unrelated instructions between producer and consumer, the consumer is held for 2, 1 and 0 cycles respectively.
- R3: `pc_hold`, `fd_hold` and `dc_bubble` are always equal: all high on a stall cycle and all low otherwise, including right after reset.
- R4: A match on either operand raises the stall. Operand 0 is bits [4:0] of `dec_src_ids` and operand 1 is bits [9:5].
- R5: A later-stage entry whose write-enable bit is low (a store or branch) never causes a stall.
- R6: A destination tag of 0 never causes a stall, because register 0 is a hardwired zero.
- R7: An invalid Decode slot never stalls, and an invalid later-stage entry (a bubble) never matches, whatever tags it carries.
- R8: A source whose use bit is low never matches.
- R9: The stall is held while any of the Compute, Memory and Writeback entries matches. When two producers are in flight, the consumer waits for the younger one to leave Writeback.
- R10: No instruction is lost or duplicated during a stall: every valid instruction leaves Writeback exactly once, in program order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (used by the built-in checks) |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode slot holds a real instruction |
| dec_src_use | input | 2 | Per-operand use bit of the Decode instruction |
| dec_src_ids | input | 10 | Operand tags of the Decode instruction, operand k at bits [5k+4:5k] |
| late_valid | input | 3 | Valid bit per later stage: bit 0 Compute, 1 Memory, 2 Writeback |
| late_wr_en | input | 3 | Register-write enable per later stage, same bit order |
| late_dst_ids | input | 15 | Destination tags, stage k at bits [5k+4:5k] |
| pc_hold | output | 1 | Keep the program counter unchanged |
| fd_hold | output | 1 | Keep the Fetch/Decode buffer contents |
| dc_bubble | output | 1 | Load a no-operation control word into the Decode/Compute buffer |

## Verification
The bench runs short instruction sequences through its own model of the five buffers and measures how long each consumer waits. A design that skipped the Writeback compare would release adjacent consumers after two cycles, and one that ignored the valid bit would keep stalling on the stale tags that the bench deliberately leaves in its bubbles. Dependent sequences with zero to three fillers, second-operand matches, store-like producers, register-0 writes and cleared use bits each catch a wrong or missing qualifier. The bench also checks that retirement order is unbroken, which shows whether a hold line failed to freeze fetch.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int REG_ID_W = 5;

    typedef logic [REG_ID_W-1:0] reg_id_t;

    localparam reg_id_t ZERO_REG = '0;

    // destination tag carried by a later interstage buffer
    typedef struct packed {
        logic    valid;
        logic    wr_en;
        reg_id_t dst;
    } dst_tag_t;

    // operand tag of the instruction in Decode
    typedef struct packed {
        logic    used;
        reg_id_t id;
    } src_tag_t;

    // true when the tag stands for a pending architectural write
    function automatic logic tag_writes(dst_tag_t t, logic zero_fixed);
        return t.valid && t.wr_en && !(zero_fixed && (t.dst == ZERO_REG));
    endfunction

endpackage

// File: rtl/hzd_dst_qual.sv
module hzd_dst_qual
    import hzd_pkg::*;
#(
    parameter bit ZERO_FIXED = 1'b1
) (
    input  dst_tag_t tag_i,
    output logic     live_o,
    output reg_id_t  dst_o
);
    assign live_o = tag_writes(tag_i, ZERO_FIXED);
    assign dst_o  = tag_i.dst;
endmodule

// File: rtl/hzd_src_match.sv
module hzd_src_match
    import hzd_pkg::*;
#(
    parameter int NUM_LATE = 3
) (
    input  logic                         dec_valid_i,
    input  src_tag_t                     src_i,
    input  logic [NUM_LATE-1:0]          live_i,
    input  logic [NUM_LATE-1:0][REG_ID_W-1:0] dst_i,
    output logic                         hit_o
);
    logic [NUM_LATE-1:0] stage_hit;

    for (genvar s = 0; s < NUM_LATE; s++) begin : g_stage
        assign stage_hit[s] = live_i[s] && (dst_i[s] == src_i.id);
    end

    assign hit_o = dec_valid_i && src_i.used && (|stage_hit);
endmodule

// File: rtl/hzd_stall_ctrl.sv
module hzd_stall_ctrl #(
    parameter int NUM_SRC  = 2,
    parameter int NUM_LATE = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] hit_i,
    output logic               pc_hold_o,
    output logic               fd_hold_o,
    output logic               dc_bubble_o
);
    localparam int RUN_W = $clog2(NUM_LATE + 2);

    logic stall;
    assign stall       = |hit_i;
    assign pc_hold_o   = stall;
    assign fd_hold_o   = stall;
    assign dc_bubble_o = stall;

    // consecutive stall cycles, saturating
    logic [RUN_W-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)
            run_len <= '0;
        else if (!stall)
            run_len <= '0;
        else if (run_len != RUN_W'(NUM_LATE + 1))
            run_len <= run_len + 1'b1;
    end

    // R1
    stall_run_chk: assert property (@(posedge clk) disable iff (rst)
        run_len <= RUN_W'(NUM_LATE));
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
    import hzd_pkg::*;
#(
    parameter int NUM_SRC    = 2,
    parameter int NUM_LATE   = 3,
    parameter bit ZERO_FIXED = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         dec_valid,
    input  logic [NUM_SRC-1:0]           dec_src_use,
    input  logic [NUM_SRC*REG_ID_W-1:0]  dec_src_ids,
    input  logic [NUM_LATE-1:0]          late_valid,
    input  logic [NUM_LATE-1:0]          late_wr_en,
    input  logic [NUM_LATE*REG_ID_W-1:0] late_dst_ids,
    output logic                         pc_hold,
    output logic                         fd_hold,
    output logic                         dc_bubble
);
    logic [NUM_LATE-1:0]               live;
    logic [NUM_LATE-1:0][REG_ID_W-1:0] dst;
    logic [NUM_SRC-1:0]                hit;

    for (genvar s = 0; s < NUM_LATE; s++) begin : g_late
        dst_tag_t tag;
        assign tag.valid = late_valid[s];
        assign tag.wr_en = late_wr_en[s];
        assign tag.dst   = late_dst_ids[s*REG_ID_W +: REG_ID_W];

        hzd_dst_qual #(.ZERO_FIXED(ZERO_FIXED)) u_qual (
            .tag_i  (tag),
            .live_o (live[s]),
            .dst_o  (dst[s])
        );
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        src_tag_t src;
        assign src.used = dec_src_use[k];
        assign src.id   = dec_src_ids[k*REG_ID_W +: REG_ID_W];

        hzd_src_match #(.NUM_LATE(NUM_LATE)) u_match (
            .dec_valid_i (dec_valid),
            .src_i       (src),
            .live_i      (live),
            .dst_i       (dst),
            .hit_o       (hit[k])
        );
    end

    hzd_stall_ctrl #(.NUM_SRC(NUM_SRC), .NUM_LATE(NUM_LATE)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .hit_i       (hit),
        .pc_hold_o   (pc_hold),
        .fd_hold_o   (fd_hold),
        .dc_bubble_o (dc_bubble)
    );

    // R5
    nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (late_wr_en == '0) |-> !pc_hold);

    // R6
    zero_dst_chk: assert property (@(posedge clk) disable iff (rst)
        (ZERO_FIXED && (late_dst_ids == '0)) |-> !pc_hold);

    // R7
    idle_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (!dec_valid || (late_valid == '0)) |-> !pc_hold);

    // R8
    unused_src_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_src_use == '0) |-> !dc_bubble);
endmodule

// File: tb/hazard_interlock_tb.sv
`timescale 1ns/1ps
module hazard_interlock_tb;
    import hzd_pkg::*;

    typedef struct packed {
        logic    valid;
        logic    we;
        reg_id_t dst;
        logic    u0;
        reg_id_t s0;
        logic    u1;
        reg_id_t s1;
        logic [3:0] idx;
    } ins_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    ins_t st_d, st_c, st_m, st_w;
    logic pc_hold, fd_hold, dc_bubble;

    hazard_interlock u_dut (
        .clk          (clk),
        .rst          (rst),
        .dec_valid    (st_d.valid),
        .dec_src_use  ({st_d.u1, st_d.u0}),
        .dec_src_ids  ({st_d.s1, st_d.s0}),
        .late_valid   ({st_w.valid, st_m.valid, st_c.valid}),
        .late_wr_en   ({st_w.we, st_m.we, st_c.we}),
        .late_dst_ids ({st_w.dst, st_m.dst, st_c.dst}),
        .pc_hold      (pc_hold),
        .fd_hold      (fd_hold),
        .dc_bubble    (dc_bubble)
    );

    int checks = 0;
    int errors = 0;

    ins_t prog [16];
    int   n_prog;
    int   stalls [16];
    int   ret_order [16];
    int   ret_cnt;
    int   mismatch;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        n_prog = 0;
    endtask

    task automatic add(input logic v, input logic we, input int dst,
                       input logic u0, input int s0, input logic u1, input int s1);
        ins_t t;
        t.valid = v; t.we = we; t.dst = reg_id_t'(dst);
        t.u0 = u0; t.s0 = reg_id_t'(s0);
        t.u1 = u1; t.s1 = reg_id_t'(s1);
        t.idx = 4'(n_prog);
        prog[n_prog] = t;
        n_prog++;
    endtask

    // pipeline model driven by the stall lines
    task automatic run_prog();
        int  pc;
        logic s;
        st_d = '0; st_c = '0; st_m = '0; st_w = '0;
        pc = 0; ret_cnt = 0; mismatch = 0;
        for (int i = 0; i < 16; i++) stalls[i] = 0;
        for (int cyc = 0; cyc < 80; cyc++) begin
            @(negedge clk);
            s = pc_hold;
            if (pc_hold !== fd_hold || pc_hold !== dc_bubble) mismatch++;
            if (s && st_d.valid) stalls[st_d.idx]++;
            @(posedge clk); #1;
            if (st_w.valid && ret_cnt < 16) begin
                ret_order[ret_cnt] = int'(st_w.idx);
                ret_cnt++;
            end
            st_w = st_m;
            st_m = st_c;
            if (s) begin
                st_c = '0;
                st_c.we  = 1'b1;       // stale tag left in the bubble
                st_c.dst = st_d.s0;
            end else begin
                st_c = st_d;
                if (pc < n_prog) st_d = prog[pc];
                else st_d = '0;
                pc++;
            end
            if (pc > n_prog && !st_d.valid && !st_c.valid && !st_m.valid && !st_w.valid)
                break;
        end
        // R3 lines agree every cycle
        chk(mismatch == 0, "R3", mismatch, 0);
        // R10 order and count
        begin
            int k;
            k = 0;
            for (int i = 0; i < n_prog; i++) begin
                if (prog[i].valid) begin
                    chk(k < ret_cnt && ret_order[k] == i, "R10", (k < ret_cnt) ? ret_order[k] : -1, i);
                    k++;
                end
            end
            chk(ret_cnt == k, "R10", ret_cnt, k);
        end
    endtask

    task automatic t_reset();
        st_d = '0; st_c = '0; st_m = '0; st_w = '0;
        @(negedge clk);
        chk(pc_hold == 1'b0 && fd_hold == 1'b0 && dc_bubble == 1'b0, "R3",
            int'({pc_hold, fd_hold, dc_bubble}), 0);
    endtask

    task automatic t_adjacent();
        clear_prog();
        add(1, 1, 2, 1, 1, 1, 3);
        add(1, 1, 4, 1, 2, 0, 0);
        run_prog();
        chk(stalls[1] == 3, "R1", stalls[1], 3);
        // chain: second consumer also produces
        clear_prog();
        add(1, 1, 1, 0, 0, 0, 0);
        add(1, 1, 2, 1, 1, 0, 0);
        add(1, 1, 3, 1, 2, 0, 0);
        run_prog();
        chk(stalls[1] == 3, "R1", stalls[1], 3);
        chk(stalls[2] == 3, "R1", stalls[2], 3);
    endtask

    task automatic t_gaps();
        for (int g = 1; g <= 3; g++) begin
            clear_prog();
            add(1, 1, 4, 0, 0, 0, 0);
            for (int f = 0; f < g; f++) add(1, 1, 9 + f, 1, 20, 0, 0);
            add(1, 1, 15, 0, 0, 1, 4);
            run_prog();
            chk(stalls[g + 1] == 3 - g, "R2", stalls[g + 1], 3 - g);
        end
    endtask

    task automatic t_src1();
        clear_prog();
        add(1, 1, 6, 0, 0, 0, 0);
        add(1, 1, 7, 1, 1, 1, 6);
        run_prog();
        chk(stalls[1] == 3, "R4", stalls[1], 3);
    endtask

    task automatic t_nowrite();
        clear_prog();
        add(1, 0, 5, 1, 2, 1, 3);
        add(1, 1, 8, 1, 5, 1, 5);
        run_prog();
        chk(stalls[1] == 0, "R5", stalls[1], 0);
    endtask

    task automatic t_zero();
        clear_prog();
        add(1, 1, 0, 1, 2, 0, 0);
        add(1, 1, 8, 1, 0, 1, 0);
        run_prog();
        chk(stalls[1] == 0, "R6", stalls[1], 0);
    endtask

    task automatic t_unused();
        clear_prog();
        add(1, 1, 5, 0, 0, 0, 0);
        add(1, 1, 8, 0, 5, 0, 5);
        run_prog();
        chk(stalls[1] == 0, "R8", stalls[1], 0);
    endtask

    task automatic t_invalid();
        // invalid Decode slot with matching tags
        clear_prog();
        add(1, 1, 5, 0, 0, 0, 0);
        add(0, 1, 6, 1, 5, 1, 5);
        add(1, 1, 7, 1, 11, 0, 0);
        run_prog();
        chk(stalls[1] == 0, "R7", stalls[1], 0);
        chk(stalls[2] == 0, "R7", stalls[2], 0);
        // bubbles carrying stale tag r2 must not hold the next reader
        clear_prog();
        add(1, 1, 2, 0, 0, 0, 0);
        add(1, 1, 13, 1, 2, 0, 0);
        add(1, 1, 14, 1, 2, 0, 0);
        run_prog();
        chk(stalls[1] == 3, "R7", stalls[1], 3);
        chk(stalls[2] == 0, "R7", stalls[2], 0);
    endtask

    task automatic t_multi();
        clear_prog();
        add(1, 1, 1, 0, 0, 0, 0);
        add(1, 1, 3, 0, 0, 0, 0);
        add(1, 1, 8, 1, 1, 1, 3);
        run_prog();
        chk(stalls[2] == 3, "R9", stalls[2], 3);
        clear_prog();
        add(1, 1, 1, 0, 0, 0, 0);
        add(1, 1, 1, 0, 0, 0, 0);
        add(1, 1, 8, 1, 1, 0, 0);
        run_prog();
        chk(stalls[2] == 3, "R9", stalls[2], 3);
        clear_prog();
        add(1, 1, 1, 0, 0, 0, 0);
        add(1, 1, 9, 1, 20, 0, 0);
        add(1, 1, 3, 0, 0, 0, 0);
        add(1, 1, 8, 1, 1, 1, 3);
        run_prog();
        chk(stalls[3] == 3, "R9", stalls[3], 3);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        st_d = '0; st_c = '0; st_m = '0; st_w = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_adjacent();
        t_gaps();
        t_src1();
        t_nowrite();
        t_zero();
        t_unused();
        t_invalid();
        t_multi();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule